// File: doc/BRIEF.md
# PCIe Inbound Message Dispatcher

This block sits behind a set of downstream root ports and turns each decoded inbound message into its side effect. Every port gives a one-cycle valid strobe with a message code. The block keeps a level per port for each of the four legacy interrupt lines and for the general-purpose event line. It ORs those levels across ports onto shared virtual wires. Error classes each raise their own system interrupt pulse, and a power-management event raises a PME pulse.

Each port also has a link power-entry handshake. When a port receives an L1 or L2/L3 entry request, it blocks new TLPs and waits until the transmit side reports no unacknowledged TLPs. It then requests that an acknowledge be sent. Attention-button messages set a per-port status bit and can raise a hot-plug interrupt. Unknown codes set an unsupported-request status bit and return their credit as a single-cycle pulse. Both status bits are cleared by writing one to them.

Every effect appears one clock after the edge that samples the strobe. The handshake is the exception, since it advances one state per clock. Fence and configuration-query messages, and turn-off acknowledges, are consumed with only a single-cycle done pulse.

Top module: `pcie_msg_dispatch`

## Requirements
- R1: Codes 0..3 raise interrupt lines A..D and codes 4..7 lower them, for the sending port only. `intx_wire[i]` (bit 0 = A) is the OR of all ports' levels for line i, visible the cycle after the strobe.
- R2: Code 8 raises and code 9 lowers the sending port's event level. `gpe_wire` is the OR of all ports' event levels.
- R3: Code 10 pulses `err_cor_irq`, code 11 pulses `err_nonfatal_irq` and code 12 pulses `err_fatal_irq`. Each pulse lasts one cycle and comes the cycle after the strobe.
- R4: Code 13 produces a one-cycle `pme_out` pulse the cycle after the strobe.
- R5: Code 14 (turn-off acknowledge), code 18 (fence) and code 19 (configuration query) produce a one-cycle `msg_done` pulse for the port and change no other output.
- R6: Code 15 (L1) or code 16 (L2/L3) raises the port's `tlp_block` the cycle after the strobe. `pm_ack_req` stays low while `tx_pending` is high. `pm_ack_req` pulses for one cycle on the clock after `tx_pending` is seen low, and `tlp_block` drops on the following clock.
- R7: An entry request that arrives while the port's handshake is busy is ignored. Only one acknowledge is issued, and `tlp_block` stays low after that acknowledge.
- R8: Code 17 sets the port's `attn_sts`. `hp_irq` pulses for that port only when both `attn_en` and `hp_irq_en` are high for that port.
- R9: `attn_clr` and `ur_clr` clear their status bits when written with one. When a set and a clear hit the same bit in the same cycle, the bit stays set.
- R10: Any code outside 0..19 sets the port's `ur_sts` and pulses `credit_ret` for one cycle. The interrupt, event, error, PME and done outputs are left unchanged.
- R11: Reset clears all interrupt and event levels, all status bits and all handshake states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | NUM_PORTS | Per-port message strobe |
| msg_code | input | NUM_PORTS*CODE_W | Per-port message code, port p at bits p*CODE_W upward |
| attn_en | input | NUM_PORTS | Attention-button interrupt enable |
| hp_irq_en | input | NUM_PORTS | Hot-plug interrupt enable |
| tx_pending | input | NUM_PORTS | High while the port has unacknowledged TLPs |
| attn_clr | input | NUM_PORTS | Write-one-to-clear for attn_sts |
| ur_clr | input | NUM_PORTS | Write-one-to-clear for ur_sts |
| intx_wire | output | 4 | Aggregated legacy interrupt lines A..D |
| gpe_wire | output | 1 | Aggregated general-purpose event wire |
| err_cor_irq | output | 1 | Correctable error interrupt pulse |
| err_nonfatal_irq | output | 1 | Uncorrectable error interrupt pulse |
| err_fatal_irq | output | 1 | Fatal error interrupt pulse |
| pme_out | output | 1 | Power-management event pulse |
| attn_sts | output | NUM_PORTS | Attention-button-pressed status |
| hp_irq | output | NUM_PORTS | Hot-plug interrupt pulse |
| ur_sts | output | NUM_PORTS | Unsupported-request status |
| credit_ret | output | NUM_PORTS | Credit-return pulse for a dropped message |
| msg_done | output | NUM_PORTS | Handled pulse for consumed messages |
| tlp_block | output | NUM_PORTS | Port must not issue new TLPs |
| pm_ack_req | output | NUM_PORTS | Request to send the power-management acknowledge |

## Verification
A status bit can be set by a message and cleared by software in the same cycle. The bench provokes this by driving an attention-button code on a port while its `attn_clr` is high, and then confirms that the bit reads one. A second cycle with only the clear must then bring it to zero. An entry request can also land while that port's handshake is still waiting for acknowledges to drain. The bench judges this by requiring exactly one `pm_ack_req` pulse and a `tlp_block` that stays low once the handshake is back at rest.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
   localparam int MSG_CODE_BITS = 5;
   localparam int INTX_LINES    = 4;
   localparam int ERR_CLASSES   = 3;

   typedef enum logic [MSG_CODE_BITS-1:0] {
      MSG_INTA_ON      = 5'd0,
      MSG_INTB_ON      = 5'd1,
      MSG_INTC_ON      = 5'd2,
      MSG_INTD_ON      = 5'd3,
      MSG_INTA_OFF     = 5'd4,
      MSG_INTB_OFF     = 5'd5,
      MSG_INTC_OFF     = 5'd6,
      MSG_INTD_OFF     = 5'd7,
      MSG_GPE_ON       = 5'd8,
      MSG_GPE_OFF      = 5'd9,
      MSG_ERR_COR      = 5'd10,
      MSG_ERR_NONFATAL = 5'd11,
      MSG_ERR_FATAL    = 5'd12,
      MSG_PME          = 5'd13,
      MSG_TURNOFF_ACK  = 5'd14,
      MSG_PM_L1        = 5'd15,
      MSG_PM_L23       = 5'd16,
      MSG_ATTN_BTN     = 5'd17,
      MSG_FENCE        = 5'd18,
      MSG_CFG_QUERY    = 5'd19
   } msg_e;

   typedef enum logic [1:0] {
      PM_IDLE  = 2'd0,
      PM_BLOCK = 2'd1,
      PM_WAIT  = 2'd2,
      PM_ACK   = 2'd3
   } pm_state_e;
endpackage

// File: rtl/pmd_pm_fsm.sv
module pmd_pm_fsm
   import pmd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic enter_req,
   input  logic acks_pending,
   output logic tlp_block,
   output logic pm_ack
);
   pm_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PM_IDLE:  if (enter_req) state_d = PM_BLOCK;
         PM_BLOCK: state_d = PM_WAIT;
         PM_WAIT:  if (!acks_pending) state_d = PM_ACK;
         PM_ACK:   state_d = PM_IDLE;
         default:  state_d = PM_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PM_IDLE;
      else        state_q <= state_d;
   end

   assign tlp_block = (state_q != PM_IDLE);
   assign pm_ack    = (state_q == PM_ACK);

   // R6
   ack_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pm_ack) |-> $past(!acks_pending && tlp_block));
   // R6
   ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pm_ack |=> !pm_ack);
   // R7
   rest_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pm_ack |=> !tlp_block);
endmodule

// File: rtl/pmd_port_decode.sv
module pmd_port_decode
   import pmd_pkg::*;
#(
   parameter int CODE_W = MSG_CODE_BITS
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   valid,
   input  logic [CODE_W-1:0]      code,
   input  logic                   attn_en,
   input  logic                   hp_en,
   input  logic                   attn_clr,
   input  logic                   ur_clr,
   output logic [INTX_LINES-1:0]  intx_lvl,
   output logic                   gpe_lvl,
   output logic [ERR_CLASSES-1:0] err_pulse,
   output logic                   pme_pulse,
   output logic                   done_pulse,
   output logic                   credit_pulse,
   output logic                   attn_sts,
   output logic                   hp_irq,
   output logic                   ur_sts,
   output logic                   pm_enter
);
   logic [INTX_LINES-1:0]  intx_set, intx_rel;
   logic                   gpe_set, gpe_rel;
   logic [ERR_CLASSES-1:0] err_hit;
   logic                   pme_hit, done_hit, attn_hit, unk_hit;

   always_comb begin
      intx_set = '0;
      intx_rel = '0;
      gpe_set  = 1'b0;
      gpe_rel  = 1'b0;
      err_hit  = '0;
      pme_hit  = 1'b0;
      done_hit = 1'b0;
      attn_hit = 1'b0;
      unk_hit  = 1'b0;
      pm_enter = 1'b0;
      if (valid) begin
         case (code)
            CODE_W'(MSG_INTA_ON):      intx_set[0] = 1'b1;
            CODE_W'(MSG_INTB_ON):      intx_set[1] = 1'b1;
            CODE_W'(MSG_INTC_ON):      intx_set[2] = 1'b1;
            CODE_W'(MSG_INTD_ON):      intx_set[3] = 1'b1;
            CODE_W'(MSG_INTA_OFF):     intx_rel[0] = 1'b1;
            CODE_W'(MSG_INTB_OFF):     intx_rel[1] = 1'b1;
            CODE_W'(MSG_INTC_OFF):     intx_rel[2] = 1'b1;
            CODE_W'(MSG_INTD_OFF):     intx_rel[3] = 1'b1;
            CODE_W'(MSG_GPE_ON):       gpe_set     = 1'b1;
            CODE_W'(MSG_GPE_OFF):      gpe_rel     = 1'b1;
            CODE_W'(MSG_ERR_COR):      err_hit[0]  = 1'b1;
            CODE_W'(MSG_ERR_NONFATAL): err_hit[1]  = 1'b1;
            CODE_W'(MSG_ERR_FATAL):    err_hit[2]  = 1'b1;
            CODE_W'(MSG_PME):          pme_hit     = 1'b1;
            CODE_W'(MSG_PM_L1),
            CODE_W'(MSG_PM_L23):       pm_enter    = 1'b1;
            CODE_W'(MSG_ATTN_BTN):     attn_hit    = 1'b1;
            CODE_W'(MSG_TURNOFF_ACK),
            CODE_W'(MSG_FENCE),
            CODE_W'(MSG_CFG_QUERY):    done_hit    = 1'b1;
            default:                   unk_hit     = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         intx_lvl     <= '0;
         gpe_lvl      <= 1'b0;
         err_pulse    <= '0;
         pme_pulse    <= 1'b0;
         done_pulse   <= 1'b0;
         credit_pulse <= 1'b0;
         attn_sts     <= 1'b0;
         hp_irq       <= 1'b0;
         ur_sts       <= 1'b0;
      end else begin
         for (int i = 0; i < INTX_LINES; i++) begin
            if (intx_set[i])      intx_lvl[i] <= 1'b1;
            else if (intx_rel[i]) intx_lvl[i] <= 1'b0;
         end
         if (gpe_set)      gpe_lvl <= 1'b1;
         else if (gpe_rel) gpe_lvl <= 1'b0;
         err_pulse    <= err_hit;
         pme_pulse    <= pme_hit;
         done_pulse   <= done_hit;
         credit_pulse <= unk_hit;
         hp_irq       <= attn_hit && attn_en && hp_en;
         attn_sts     <= attn_hit | (attn_sts & ~attn_clr);
         ur_sts       <= unk_hit  | (ur_sts   & ~ur_clr);
      end
   end

   // R3
   err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_pulse) |-> $past(valid));
   // R3
   err_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(err_pulse));
   // R8
   hp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hp_irq |-> ($past(attn_en && hp_en) && attn_sts));
   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      attn_hit |=> attn_sts);
   // R10
   credit_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      credit_pulse |-> ur_sts);
endmodule

// File: rtl/pcie_msg_dispatch.sv
module pcie_msg_dispatch
   import pmd_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int CODE_W    = MSG_CODE_BITS
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_PORTS-1:0]        msg_valid,
   input  logic [NUM_PORTS*CODE_W-1:0] msg_code,
   input  logic [NUM_PORTS-1:0]        attn_en,
   input  logic [NUM_PORTS-1:0]        hp_irq_en,
   input  logic [NUM_PORTS-1:0]        tx_pending,
   input  logic [NUM_PORTS-1:0]        attn_clr,
   input  logic [NUM_PORTS-1:0]        ur_clr,
   output logic [INTX_LINES-1:0]       intx_wire,
   output logic                        gpe_wire,
   output logic                        err_cor_irq,
   output logic                        err_nonfatal_irq,
   output logic                        err_fatal_irq,
   output logic                        pme_out,
   output logic [NUM_PORTS-1:0]        attn_sts,
   output logic [NUM_PORTS-1:0]        hp_irq,
   output logic [NUM_PORTS-1:0]        ur_sts,
   output logic [NUM_PORTS-1:0]        credit_ret,
   output logic [NUM_PORTS-1:0]        msg_done,
   output logic [NUM_PORTS-1:0]        tlp_block,
   output logic [NUM_PORTS-1:0]        pm_ack_req
);
   localparam int MAX_PORTS = 32;

   if (NUM_PORTS < 1 || NUM_PORTS > MAX_PORTS) begin : g_bad_ports
      $error("NUM_PORTS out of range");
   end
   if (CODE_W < MSG_CODE_BITS) begin : g_bad_code
      $error("CODE_W too narrow for the message set");
   end

   logic [INTX_LINES-1:0]  intx_p   [NUM_PORTS];
   logic [ERR_CLASSES-1:0] err_p    [NUM_PORTS];
   logic [NUM_PORTS-1:0]   gpe_p, pme_p, enter_p;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      pmd_port_decode #(.CODE_W(CODE_W)) u_dec (
         .clk          (clk),
         .rst_n        (rst_n),
         .valid        (msg_valid[p]),
         .code         (msg_code[p*CODE_W +: CODE_W]),
         .attn_en      (attn_en[p]),
         .hp_en        (hp_irq_en[p]),
         .attn_clr     (attn_clr[p]),
         .ur_clr       (ur_clr[p]),
         .intx_lvl     (intx_p[p]),
         .gpe_lvl      (gpe_p[p]),
         .err_pulse    (err_p[p]),
         .pme_pulse    (pme_p[p]),
         .done_pulse   (msg_done[p]),
         .credit_pulse (credit_ret[p]),
         .attn_sts     (attn_sts[p]),
         .hp_irq       (hp_irq[p]),
         .ur_sts       (ur_sts[p]),
         .pm_enter     (enter_p[p])
      );

      pmd_pm_fsm u_pm (
         .clk          (clk),
         .rst_n        (rst_n),
         .enter_req    (enter_p[p]),
         .acks_pending (tx_pending[p]),
         .tlp_block    (tlp_block[p]),
         .pm_ack       (pm_ack_req[p])
      );
   end

   logic [ERR_CLASSES-1:0] err_any;

   always_comb begin
      intx_wire = '0;
      err_any   = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         intx_wire = intx_wire | intx_p[p];
         err_any   = err_any   | err_p[p];
      end
   end

   assign gpe_wire         = |gpe_p;
   assign pme_out          = |pme_p;
   assign err_cor_irq      = err_any[0];
   assign err_nonfatal_irq = err_any[1];
   assign err_fatal_irq    = err_any[2];

   // R11
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (intx_wire == '0 && !gpe_wire && attn_sts == '0 && tlp_block == '0));
   // R1
   wire_needs_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(intx_wire[0]) |-> $past(|msg_valid));
endmodule

// File: tb/tb_pcie_msg_dispatch.sv
module tb_pcie_msg_dispatch;
   localparam int NP = 4;
   localparam int CW = 5;
   localparam int NV = 22;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0]    msg_valid = '0;
   logic [NP*CW-1:0] msg_code  = '0;
   logic [NP-1:0]    attn_en = '0, hp_irq_en = '0, tx_pending = '0;
   logic [NP-1:0]    attn_clr = '0, ur_clr = '0;
   logic [3:0]       intx_wire;
   logic             gpe_wire, err_cor_irq, err_nonfatal_irq, err_fatal_irq, pme_out;
   logic [NP-1:0]    attn_sts, hp_irq, ur_sts, credit_ret, msg_done, tlp_block, pm_ack_req;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   pcie_msg_dispatch #(.NUM_PORTS(NP), .CODE_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_code(msg_code),
      .attn_en(attn_en), .hp_irq_en(hp_irq_en), .tx_pending(tx_pending),
      .attn_clr(attn_clr), .ur_clr(ur_clr), .intx_wire(intx_wire),
      .gpe_wire(gpe_wire), .err_cor_irq(err_cor_irq),
      .err_nonfatal_irq(err_nonfatal_irq), .err_fatal_irq(err_fatal_irq),
      .pme_out(pme_out), .attn_sts(attn_sts), .hp_irq(hp_irq), .ur_sts(ur_sts),
      .credit_ret(credit_ret), .msg_done(msg_done), .tlp_block(tlp_block),
      .pm_ack_req(pm_ack_req)
   );

   // {port, code, intx, gpe, err{fatal,nonfatal,cor}, pme, done, credit}
   localparam logic [17:0] VEC [NV] = '{
      {2'd0, 5'd0,  4'b0001, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0},
      {2'd1, 5'd0,  4'b0001, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0},
      {2'd0, 5'd4,  4'b0001, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0},
      {2'd1, 5'd4,  4'b0000, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0},
      {2'd2, 5'd2,  4'b0100, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0},
      {2'd3, 5'd3,  4'b1100, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0},
      {2'd2, 5'd6,  4'b1000, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0},
      {2'd3, 5'd7,  4'b0000, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0},
      {2'd0, 5'd8,  4'b0000, 1'b1, 3'b000, 1'b0, 1'b0, 1'b0},
      {2'd3, 5'd8,  4'b0000, 1'b1, 3'b000, 1'b0, 1'b0, 1'b0},
      {2'd0, 5'd9,  4'b0000, 1'b1, 3'b000, 1'b0, 1'b0, 1'b0},
      {2'd3, 5'd9,  4'b0000, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0},
      {2'd1, 5'd10, 4'b0000, 1'b0, 3'b001, 1'b0, 1'b0, 1'b0},
      {2'd2, 5'd11, 4'b0000, 1'b0, 3'b010, 1'b0, 1'b0, 1'b0},
      {2'd3, 5'd12, 4'b0000, 1'b0, 3'b100, 1'b0, 1'b0, 1'b0},
      {2'd0, 5'd13, 4'b0000, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0},
      {2'd1, 5'd14, 4'b0000, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0},
      {2'd2, 5'd18, 4'b0000, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0},
      {2'd3, 5'd19, 4'b0000, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0},
      {2'd0, 5'd31, 4'b0000, 1'b0, 3'b000, 1'b0, 1'b0, 1'b1},
      {2'd1, 5'd1,  4'b0010, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0},
      {2'd1, 5'd5,  4'b0000, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0}
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // drive one strobe; returns at the falling edge after the sampling edge
   task automatic send(int p, logic [4:0] c);
      @(negedge clk);
      msg_valid = '0;
      msg_valid[p] = 1'b1;
      msg_code[p*CW +: CW] = c;
      @(negedge clk);
      msg_valid = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 intx at reset", 32'(intx_wire), 0);
      check("R11 status at reset", 32'({attn_sts, ur_sts, tlp_block}), 0);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         send(int'(VEC[v][17:16]), VEC[v][15:11]);
         check("R1 intx wire", 32'(intx_wire), 32'(VEC[v][10:7]));
         check("R2 event wire", 32'(gpe_wire), 32'(VEC[v][6]));
         check("R3 error irq", 32'({err_fatal_irq, err_nonfatal_irq, err_cor_irq}), 32'(VEC[v][5:3]));
         check("R4 pme", 32'(pme_out), 32'(VEC[v][2]));
         check("R5 done", 32'(|msg_done), 32'(VEC[v][1]));
         check("R10 credit", 32'(|credit_ret), 32'(VEC[v][0]));
      end

      // R10 status from the unknown code, then clear
      check("R10 ur status", 32'(ur_sts), 32'h1);
      @(negedge clk); ur_clr[0] = 1'b1;
      @(negedge clk); ur_clr[0] = 1'b0;
      check("R9 ur clear", 32'(ur_sts), 0);

      // R6 handshake with acks outstanding
      tx_pending[0] = 1'b1;
      send(0, 5'd15);
      check("R6 block raised", 32'(tlp_block), 32'h1);
      check("R6 no early ack", 32'(pm_ack_req), 0);
      repeat (3) @(negedge clk);
      check("R6 wait while pending", 32'({tlp_block, pm_ack_req}), 32'h10);
      // R7 request while busy
      send(0, 5'd16);
      check("R7 still waiting", 32'({tlp_block, pm_ack_req}), 32'h10);
      tx_pending[0] = 1'b0;
      @(negedge clk);
      check("R6 ack after drain", 32'(pm_ack_req), 32'h1);
      @(negedge clk);
      check("R6 ack single", 32'(pm_ack_req), 0);
      check("R6 unblock", 32'(tlp_block), 0);
      repeat (2) @(negedge clk);
      check("R7 request dropped", 32'({tlp_block, pm_ack_req}), 0);

      // R8 attention with only one enable
      attn_en[2] = 1'b1;
      send(2, 5'd17);
      check("R8 status set", 32'(attn_sts), 32'h4);
      check("R8 no irq one enable", 32'(hp_irq), 0);
      hp_irq_en[2] = 1'b1;
      send(2, 5'd17);
      check("R8 irq both enables", 32'(hp_irq), 32'h4);

      // R9 set wins over clear
      @(negedge clk);
      msg_valid[2] = 1'b1; msg_code[2*CW +: CW] = 5'd17; attn_clr[2] = 1'b1;
      @(negedge clk);
      msg_valid = '0; attn_clr[2] = 1'b0;
      check("R9 set wins", 32'(attn_sts), 32'h4);
      attn_clr[2] = 1'b1;
      @(negedge clk);
      attn_clr[2] = 1'b0;
      check("R9 clear alone", 32'(attn_sts), 0);

      // R11 reset mid-operation
      send(0, 5'd0);
      send(3, 5'd17);
      tx_pending[1] = 1'b1;
      send(1, 5'd15);
      check("R11 pre-reset", 32'({intx_wire[0], attn_sts[3], tlp_block[1]}), 32'h7);
      rst_n = 1'b0;
      @(negedge clk);
      check("R11 cleared", 32'({intx_wire, attn_sts, tlp_block}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule